// File: doc/BRIEF.md
# SWD Host Request Engine

This block is the host end of a two-wire serial debug link. It runs one debug-port or access-port register transfer at a time. A request carries the port select, the direction, two register-address bits and, for a write, a data word. The engine clocks the transfer out on a serial clock, drives and releases a bidirectional data line, and waits for the target's three-bit response. It then moves the data word and its parity in whichever direction the request calls for. When the transfer ends it returns the response code, the read word and two error flags: one for a read parity mismatch and one for an undefined response.

A transfer is synchronous and fails fast. A WAIT, FAULT or undefined response ends it without a data phase. Two values come from a local wire-control register: the turnaround length (1 to 4 serial clocks) and the serial-clock prescale. The engine copies both when it accepts a request, so a write to the register during a transfer takes effect only on the next one. The data line is presented as separate output, output-enable and input pins for a pad with a pull-up.

Top module: `swd_host_engine`

## Requirements
- R1: The header goes out LSB first as 8 bits. Bit 0 is 1, bit 1 is the port select (1 = access port), bit 2 is the direction (1 = read), bits 3 and 4 are address bits A2 and A3, bit 5 is the XOR of bits 1 to 4, bit 6 is 0, and bit 7 is the park bit.
- R2: swdio_oe_o is 0 during the park bit, every turnaround clock, the three response bits and all read data and parity bits. It is 1 during header bits 0 to 6, write data and parity, and idle.
- R3: Each turnaround lasts cfg_wdata_i[9:8]+1 serial clocks. After reset this value is 1. A transfer with an OK response is 44+2*T serial clocks long, and any other transfer is 11+2*T, where T is the turnaround length.
- R4: swclk_o is low when idle and changes once every prescale+1 system clocks, where prescale is cfg_wdata_i[2:0]. done_o rises 2*N*(prescale+1) system clocks after the accepting edge, where N is the transfer length in serial clocks.
- R5: The response is sampled LSB first on rising serial-clock edges and returned on ack_o. The code 3'b001 (OK) starts the data phase.
- R6: A response of 3'b010 (WAIT) or 3'b100 (FAULT) skips the data phase, leaves rdata_o at 0 and leaves proto_err_o at 0.
- R7: Any other response value sets proto_err_o and skips the data phase.
- R8: On a write with an OK response, a turnaround follows the response. The 32-bit word then goes out LSB first, followed by its even-parity bit (the XOR of all data bits).
- R9: On a read with an OK response, 32 bits are captured LSB first into rdata_o. parity_err_o is set when the received parity bit differs from the XOR of those bits. A turnaround follows, and then the host drives the line again.
- R10: A request is accepted only when busy_o is 0. A request raised while busy is ignored. done_o is a one-cycle pulse on the cycle busy_o falls.
- R11: During and after reset, busy_o, done_o and swclk_o are 0, swdio_oe_o is 1, swdio_o is 0 and ack_o is 0.
- R12: The turnaround and prescale values are copied when a request is accepted. A wire-control write during a transfer does not change that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_ap_i | input | 1 | 1 selects access port, 0 debug port |
| req_rnw_i | input | 1 | 1 for read, 0 for write |
| req_addr_i | input | 2 | Register address bits A[3:2] |
| req_wdata_i | input | 32 | Write data |
| cfg_we_i | input | 1 | Wire-control register write strobe |
| cfg_wdata_i | input | 10 | [9:8] turnaround-1, [2:0] prescale |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| ack_o | output | 3 | Response code of last transfer |
| rdata_o | output | 32 | Read data of last transfer |
| parity_err_o | output | 1 | Read data parity mismatch |
| proto_err_o | output | 1 | Undefined response code |
| swclk_o | output | 1 | Serial clock |
| swdio_o | output | 1 | Data line output value |
| swdio_oe_o | output | 1 | Data line output enable |
| swdio_i | input | 1 | Data line input |

## Verification
The bench builds the block with its default parameters: a 32-bit data word, a 2-bit turnaround field and a 3-bit prescale. It sweeps every turnaround length from 1 to 4 against prescale values 0 to 2, and for each pair it tries all sixteen header combinations. That covers every header parity case, both directions and the length of each phase. Separate transfers return WAIT, FAULT and several undefined response codes, and some reads carry a wrong parity bit. One transfer is disturbed by a request and a wire-control write while busy, to show the engine ignores the first and defers the second.

// File: rtl/swd_host_pkg.sv
package swd_host_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_TRN1, ST_ACK, ST_TRN2, ST_WDATA, ST_RDATA, ST_TRN3
  } swd_state_e;

  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;

  function automatic logic [7:0] build_hdr(input logic ap, input logic rnw,
                                           input logic [1:0] addr);
    return {1'b1, 1'b0, ^{addr, rnw, ap}, addr[1], addr[0], rnw, ap, 1'b1};
  endfunction
endpackage

// File: rtl/swd_wire_cfg.sv
module swd_wire_cfg #(
  parameter int TRN_W   = 2,
  parameter int PRE_W   = 3,
  parameter int TRN_LSB = 8,
  parameter int CFG_W   = TRN_LSB + TRN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [TRN_W-1:0] trn_m1_o,
  output logic [PRE_W-1:0] prescale_o
);
  logic unused_gap;
  assign unused_gap = ^wdata_i[TRN_LSB-1:PRE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trn_m1_o   <= '0;
      prescale_o <= '0;
    end else if (we_i) begin
      trn_m1_o   <= wdata_i[TRN_LSB +: TRN_W];
      prescale_o <= wdata_i[PRE_W-1:0];
    end
  end

  p_cfg_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> trn_m1_o == $past(wdata_i[TRN_LSB +: TRN_W]));
endmodule

// File: rtl/swd_clk_div.sv
module swd_clk_div #(
  parameter int PRE_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PRE_W-1:0] prescale_i,
  output logic             swclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [PRE_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = run_i && (cnt_q == prescale_i);
  assign rise_o = wrap && !swclk_o;
  assign fall_o = wrap && swclk_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      swclk_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q   <= '0;
      swclk_o <= 1'b0;
    end else if (wrap) begin
      cnt_q   <= '0;
      swclk_o <= !swclk_o;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  p_hold_half_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !rise_o && !fall_o |=> $stable(swclk_o));
endmodule

// File: rtl/swd_host_engine.sv
module swd_host_engine
  import swd_host_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int TRN_W   = 2,
  parameter int PRE_W   = 3,
  parameter int TRN_LSB = 8,
  parameter int CFG_W   = TRN_LSB + TRN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_ap_i,
  input  logic              req_rnw_i,
  input  logic [1:0]        req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [2:0]        ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              parity_err_o,
  output logic              proto_err_o,
  output logic              swclk_o,
  output logic              swdio_o,
  output logic              swdio_oe_o,
  input  logic              swdio_i
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int IDX_W = $clog2(DATA_W);

  logic [TRN_W-1:0]  cfg_trn_m1, trn_q;
  logic [PRE_W-1:0]  cfg_pre, pre_q;
  logic              rise, fall;
  swd_state_e        state_q;
  logic [CNT_W-1:0]  bitcnt_q;
  logic [7:0]        hdr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rnw_q, busy_q, done_q, perr_q, proto_q;
  logic [2:0]        ack_q;
  logic              accept, trn_end, data_end;

  swd_wire_cfg #(.TRN_W(TRN_W), .PRE_W(PRE_W), .TRN_LSB(TRN_LSB), .CFG_W(CFG_W)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .wdata_i(cfg_wdata_i),
    .trn_m1_o(cfg_trn_m1), .prescale_o(cfg_pre)
  );

  swd_clk_div #(.PRE_W(PRE_W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(busy_q), .prescale_i(pre_q),
    .swclk_o(swclk_o), .rise_o(rise), .fall_o(fall)
  );

  assign accept   = req_valid_i && !busy_q;
  assign trn_end  = (bitcnt_q == CNT_W'(trn_q));
  assign data_end = (bitcnt_q == CNT_W'(DATA_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      trn_q    <= '0;
      pre_q    <= '0;
      hdr_q    <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rnw_q    <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      perr_q   <= 1'b0;
      proto_q  <= 1'b0;
      ack_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q   <= 1'b1;
        state_q  <= ST_HDR;
        bitcnt_q <= '0;
        trn_q    <= cfg_trn_m1;
        pre_q    <= cfg_pre;
        hdr_q    <= build_hdr(req_ap_i, req_rnw_i, req_addr_i);
        wdata_q  <= req_wdata_i;
        rnw_q    <= req_rnw_i;
        rdata_q  <= '0;
        ack_q    <= '0;
        perr_q   <= 1'b0;
        proto_q  <= 1'b0;
      end else if (busy_q) begin
        if (rise) begin
          if (state_q == ST_ACK) begin
            ack_q[bitcnt_q[1:0]] <= swdio_i;
          end else if (state_q == ST_RDATA) begin
            if (!data_end) rdata_q <= {swdio_i, rdata_q[DATA_W-1:1]};
            else           perr_q  <= swdio_i ^ (^rdata_q);
          end
        end
        if (fall) begin
          bitcnt_q <= bitcnt_q + 1'b1;
          unique case (state_q)
            ST_HDR: if (bitcnt_q == CNT_W'(7)) begin
              state_q <= ST_TRN1; bitcnt_q <= '0;
            end
            ST_TRN1: if (trn_end) begin
              state_q <= ST_ACK; bitcnt_q <= '0;
            end
            ST_ACK: if (bitcnt_q == CNT_W'(2)) begin
              bitcnt_q <= '0;
              if (ack_q == ACK_OK) begin
                state_q <= rnw_q ? ST_RDATA : ST_TRN2;
              end else begin
                state_q <= ST_TRN3;
                proto_q <= !(ack_q == ACK_WAIT || ack_q == ACK_FAULT);
              end
            end
            ST_TRN2: if (trn_end) begin
              state_q <= ST_WDATA; bitcnt_q <= '0;
            end
            ST_WDATA: if (data_end) begin
              state_q <= ST_IDLE; busy_q <= 1'b0; done_q <= 1'b1;
            end
            ST_RDATA: if (data_end) begin
              state_q <= ST_TRN3; bitcnt_q <= '0;
            end
            ST_TRN3: if (trn_end) begin
              state_q <= ST_IDLE; busy_q <= 1'b0; done_q <= 1'b1;
            end
            default: begin
              state_q <= ST_IDLE; busy_q <= 1'b0;
            end
          endcase
        end
      end
    end
  end

  // line drive: host owns it only for header, write data and idle
  always_comb begin
    swdio_oe_o = 1'b0;
    swdio_o    = 1'b0;
    unique case (state_q)
      ST_IDLE:  swdio_oe_o = 1'b1;
      ST_HDR: begin
        swdio_oe_o = (bitcnt_q != CNT_W'(7));
        swdio_o    = hdr_q[bitcnt_q[2:0]];
      end
      ST_WDATA: begin
        swdio_oe_o = 1'b1;
        swdio_o    = data_end ? ^wdata_q : wdata_q[bitcnt_q[IDX_W-1:0]];
      end
      default: ;
    endcase
  end

  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign ack_o        = ack_q;
  assign rdata_o      = rdata_q;
  assign parity_err_o = perr_q;
  assign proto_err_o  = proto_q;

  p_accept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !busy_o |=> busy_o && state_q == ST_HDR);
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_ends_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  p_idle_clk_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !swclk_o);
  p_release_on_sample_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise && (state_q == ST_ACK || state_q == ST_RDATA || state_q == ST_TRN1) |-> !swdio_oe_o);
  p_skip_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall && state_q == ST_ACK && bitcnt_q == CNT_W'(2) && ack_q != ACK_OK |=> state_q == ST_TRN3);
endmodule

// File: tb/tb_swd_host_engine.sv
module tb_swd_host_engine;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_ap_i = 1'b0, req_rnw_i = 1'b0;
  logic [1:0]  req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [9:0]  cfg_wdata_i = '0;
  logic        busy_o, done_o, parity_err_o, proto_err_o;
  logic [2:0]  ack_o;
  logic [31:0] rdata_o;
  logic        swclk_o, swdio_o, swdio_oe_o, swdio_i;

  int checks = 0, errors = 0;
  int t_trn = 1, t_pre = 0, k = 0;
  logic [2:0]  t_ack = 3'b001;
  logic        t_rnw = 1'b0, t_bad = 1'b0;
  logic [31:0] t_rdata = '0;
  logic        cap_out [128];
  logic        cap_oe  [128];
  logic        tv;

  always #(CLK_P/2) clk_i = !clk_i;

  swd_host_engine dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ap_i(req_ap_i),
    .req_rnw_i(req_rnw_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i), .busy_o(busy_o), .done_o(done_o),
    .ack_o(ack_o), .rdata_o(rdata_o), .parity_err_o(parity_err_o),
    .proto_err_o(proto_err_o), .swclk_o(swclk_o), .swdio_o(swdio_o),
    .swdio_oe_o(swdio_oe_o), .swdio_i(swdio_i)
  );

  // target model: value it presents for the bit sampled at rise number k
  always_comb begin
    logic [5:0] j;
    tv = 1'b1;
    j  = '0;
    if (k >= 8 + t_trn && k < 11 + t_trn) begin
      j  = 6'(k - 8 - t_trn);
      tv = t_ack[j[1:0]];
    end else if (t_ack == 3'b001 && t_rnw && k >= 11 + t_trn && k < 43 + t_trn) begin
      j  = 6'(k - 11 - t_trn);
      tv = t_rdata[j[4:0]];
    end else if (t_ack == 3'b001 && t_rnw && k == 43 + t_trn) begin
      tv = (^t_rdata) ^ t_bad;
    end
    swdio_i = swdio_oe_o ? swdio_o : tv;
  end

  always @(posedge swclk_o) begin
    if (k < 128) begin
      cap_out[k] = swdio_o;
      cap_oe[k]  = swdio_oe_o;
    end
    k = k + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int trn, input int pre);
    @(negedge clk_i);
    cfg_we_i    = 1'b1;
    cfg_wdata_i = {2'(trn - 1), 5'b0, 3'(pre)};
    @(negedge clk_i);
    cfg_we_i    = 1'b0;
    t_trn = trn;
    t_pre = pre;
  endtask

  task automatic run_txn(input logic ap, input logic rnw, input logic [1:0] addr,
                         input logic [31:0] wd, input logic [2:0] ack,
                         input logic [31:0] rd, input logic bad, input bit disturb);
    int cyc, nbits, ok_oe, ok_d, base;
    logic [6:0] hv, hexp;
    bit ok;
    t_ack = ack; t_rnw = rnw; t_rdata = rd; t_bad = bad; k = 0;
    @(negedge clk_i);
    req_ap_i = ap; req_rnw_i = rnw; req_addr_i = addr; req_wdata_i = wd;
    req_valid_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    cyc = 0;
    forever begin
      @(posedge clk_i);
      cyc++;
      @(negedge clk_i);
      if (done_o) break;
      if (cyc > 20000) break;
      if (disturb && cyc == 10) begin
        req_valid_i = 1'b1; req_ap_i = !ap; req_rnw_i = !rnw; req_addr_i = ~addr;
        cfg_we_i = 1'b1; cfg_wdata_i = {2'b11, 5'b0, 3'd0};
      end else if (disturb && cyc == 11) begin
        req_valid_i = 1'b0; cfg_we_i = 1'b0;
      end
    end
    ok    = (ack == 3'b001);
    nbits = ok ? 44 + 2 * t_trn : 11 + 2 * t_trn;
    chk(cyc == 2 * nbits * (t_pre + 1), "R4", "cycles to done", cyc, 2 * nbits * (t_pre + 1));
    chk(k == nbits, "R3", "serial clocks", k, nbits);
    for (int i = 0; i < 7; i++) hv[i] = cap_out[i] & cap_oe[i];
    hexp = {^{addr, rnw, ap}, addr[1], addr[0], rnw, ap, 1'b1} & 7'h3f;
    hexp = {1'b0, ^{addr, rnw, ap}, addr[1], addr[0], rnw, ap, 1'b1};
    chk(hv == hexp, "R1", "header bits", hv, hexp);
    ok_oe = 1;
    for (int i = 7; i < 11 + t_trn; i++) if (cap_oe[i] !== 1'b0) ok_oe = 0;
    for (int i = 0; i < 7; i++) if (cap_oe[i] !== 1'b1) ok_oe = 0;
    chk(ok_oe == 1, "R2", "release in park/turnaround/ack", ok_oe, 1);
    chk(ack_o == ack, "R5", "ack code", ack_o, ack);
    chk(proto_err_o == !(ack == 3'b001 || ack == 3'b010 || ack == 3'b100), "R7",
        "protocol error flag", proto_err_o, !(ack == 3'b001 || ack == 3'b010 || ack == 3'b100));
    base = 11 + t_trn;
    if (ok && !rnw) begin
      ok_oe = 1; ok_d = 1;
      for (int i = 0; i < t_trn; i++) if (cap_oe[base + i] !== 1'b0) ok_oe = 0;
      for (int i = 0; i < 33; i++) begin
        if (cap_oe[base + t_trn + i] !== 1'b1) ok_oe = 0;
        if (cap_out[base + t_trn + i] !== ((i == 32) ? ^wd : wd[i])) ok_d = 0;
      end
      chk(ok_oe == 1, "R8", "write drive window", ok_oe, 1);
      chk(ok_d == 1, "R8", "write data and parity", ok_d, 1);
    end else if (ok && rnw) begin
      ok_oe = 1;
      for (int i = 0; i < 33 + t_trn; i++) if (cap_oe[base + i] !== 1'b0) ok_oe = 0;
      chk(ok_oe == 1, "R9", "read release window", ok_oe, 1);
      chk(rdata_o == rd, "R9", "read data", rdata_o, rd);
      chk(parity_err_o == bad, "R9", "parity error flag", parity_err_o, bad);
    end else begin
      ok_oe = 1;
      for (int i = 0; i < t_trn; i++) if (cap_oe[base + i] !== 1'b0) ok_oe = 0;
      chk(ok_oe == 1, "R6", "trailing turnaround", ok_oe, 1);
      chk(rdata_o == 32'h0, "R6", "no data on failed ack", rdata_o, 0);
    end
    @(negedge clk_i);
    chk(done_o == 1'b0, "R10", "done pulse width", done_o, 0);
    if (disturb) begin
      repeat (4) @(negedge clk_i);
      chk(busy_o == 1'b0, "R10", "request while busy ignored", busy_o, 0);
    end
  endtask

  initial begin
    #(CLK_P * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(busy_o == 0 && done_o == 0 && swclk_o == 0, "R11", "reset busy/done/clk",
        {busy_o, done_o, swclk_o}, 0);
    chk(swdio_oe_o == 1 && swdio_o == 0 && ack_o == 0, "R11", "reset line and ack",
        {swdio_oe_o, swdio_o, ack_o}, 5'b10000);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // defaults after reset: one turnaround clock, no prescale (R3)
    run_txn(1'b0, 1'b1, 2'b00, 32'h0, 3'b001, 32'h2ba0_1477, 1'b0, 1'b0);

    for (int trn = 1; trn <= 4; trn++) begin
      for (int pre = 0; pre <= 2; pre++) begin
        set_cfg(trn, pre);
        for (int c = 0; c < 16; c++) begin
          logic [3:0] cv;
          cv = 4'(c);
          run_txn(cv[0], cv[1], cv[3:2], 32'h9e37_79b9 * (c + 1) ^ 32'(trn),
                  3'b001, 32'h7f4a_7c15 * (c + 3) + 32'(pre), cv[0] ^ cv[2], 1'b0);
        end
      end
    end

    set_cfg(2, 1);
    run_txn(1'b1, 1'b0, 2'b10, 32'h1234_5678, 3'b010, 32'h0, 1'b0, 1'b0);
    run_txn(1'b1, 1'b1, 2'b01, 32'h0, 3'b100, 32'hffff_ffff, 1'b0, 1'b0);
    run_txn(1'b0, 1'b1, 2'b11, 32'h0, 3'b111, 32'h5555_aaaa, 1'b0, 1'b0);
    run_txn(1'b0, 1'b0, 2'b00, 32'hdead_beef, 3'b000, 32'h0, 1'b0, 1'b0);
    run_txn(1'b1, 1'b0, 2'b01, 32'hcafe_f00d, 3'b011, 32'h0, 1'b0, 1'b0);
    run_txn(1'b0, 1'b1, 2'b10, 32'h0, 3'b110, 32'h0f0f_0f0f, 1'b0, 1'b0);
    run_txn(1'b1, 1'b1, 2'b11, 32'h0, 3'b001, 32'h8000_0001, 1'b1, 1'b0);

    // R12: config written mid-transfer applies to the next transfer only
    run_txn(1'b0, 1'b0, 2'b01, 32'ha5a5_0ff0, 3'b001, 32'h0, 1'b0, 1'b1);
    t_trn = 4;
    t_pre = 0;
    run_txn(1'b1, 1'b1, 2'b00, 32'h0, 3'b001, 32'h3c3c_c3c3, 1'b0, 1'b0);
    chk(k == 52, "R12", "new turnaround after deferred write", k, 52);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule